// File: doc/BRIEF.md
# Serial Audio Receiver with Silence Auto-Mute

This block takes stereo PCM audio from a three-wire serial port (bit clock, data, and a left/right word clock) and rebuilds 16-bit left and right sample words in the system clock domain. The system clock is nominally 256 times the frame rate. The bit clock must be slow enough that every serial bit lasts several system clocks. A static format pin selects one of two framings. In I2S framing the word starts one bit clock after the word clock changes. In left-justified framing the word starts on the bit clock where the word clock changes.

Each finished left/right pair is presented together with a one-cycle valid strobe. The block also produces a mute decision from two sources. The first is an external mute request. The second is a silence detector that counts consecutive pairs in which both words are zero. It raises an automatic mute once that count reaches a threshold, and drops it on the first pair that holds a non-zero word.

The framing engine is a four-state machine with the states ST_IDLE, ST_HUNT, ST_SHIFT and ST_FULL. ST_IDLE moves to ST_HUNT on the first bit clock after reset, and that bit clock records the word clock level. ST_HUNT moves to ST_SHIFT on the first word clock change. ST_SHIFT moves to ST_FULL once 16 bits are held. ST_SHIFT and ST_FULL both go back to ST_SHIFT on every word clock change, which closes the current word and opens the next one.

Top module: `pcm_rx_automute`

## Requirements
- R1: While reset is held and after it is released, `left_o`, `right_o` and `pair_valid_o` are 0 and `automute_o` is 0. No pair is produced until a word clock transition has been seen after the first bit clock.
- R2: With `fmt_i2s`=1, data is taken on bit clock rising edges, MSB first. The MSB is the bit one bit clock after a word clock change, and words sent while the word clock is 0 are left-channel words.
- R3: With `fmt_i2s`=0, the MSB is the bit on the bit clock where the word clock changes, and words sent while the word clock is 1 are left-channel words.
- R4: Words of up to 24 bits are accepted. The first 16 bits received are kept and every later bit of that word is discarded.
- R5: Each left word followed by a right word is delivered on `left_o`/`right_o` with a single-cycle `pair_valid_o`. The outputs change only in that cycle, and a right word with no preceding left word is dropped.
- R6: `automute_o` rises in the cycle after the delivery of the ZERO_RUN-th consecutive pair in which both words are zero (default 2048), and not earlier.
- R7: `automute_o` stays high while further all-zero pairs arrive. The run count saturates.
- R8: The first delivered pair with a non-zero word on either channel clears `automute_o` in the next cycle and restarts the run count from zero.
- R9: `mute_o` is high whenever `mute_ext_i` is high or `automute_o` is high, whatever the data, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i2s | input | 1 | Static framing select: 1 = I2S, 0 = left-justified |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| lrck_i | input | 1 | Left/right word clock |
| mute_ext_i | input | 1 | External mute request, active high |
| left_o | output | 16 | Left sample of the last delivered pair |
| right_o | output | 16 | Right sample of the last delivered pair |
| pair_valid_o | output | 1 | One-cycle strobe for a new pair |
| automute_o | output | 1 | Silence detector verdict |
| mute_o | output | 1 | Combined mute state |

## Verification
The external mute and the silence detector can both act on `mute_o` at once. The bench provokes this by holding `mute_ext_i` high while an all-zero run reaches the threshold, and again while the run is still short of it. It then releases the external request while the automatic mute is still active. In every case it judges that `mute_o` stays high for as long as either source is active, and that `automute_o` keeps following the data alone, rising and falling on the predicted pair deliveries.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SHIFT,
        ST_FULL
    } rx_state_e;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_i;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/frame_deser.sv
module frame_deser
    import pcm_rx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         i2s_mode,
    input  logic         bclk_s,
    input  logic         data_s,
    input  logic         lr_s,
    output logic [W-1:0] left_q,
    output logic [W-1:0] right_q,
    output logic         pair_valid
);
    localparam int CW = $clog2(W + 1);

    rx_state_e    state, nxt;
    logic [W-1:0] sh;
    logic [W-1:0] left_hold;
    logic [CW-1:0] cnt;
    logic         have_left;
    logic         lr_prev;
    logic         bclk_d;

    logic          bit_stb;
    logic          lr_chg;
    logic          appended;
    logic          close_word;
    logic          closed_left;
    logic [W-1:0]  asm_word;
    logic [W-1:0]  closed;
    logic [CW-1:0] n_close;
    logic [CW-1:0] shamt;

    always_comb begin
        bit_stb     = bclk_s && !bclk_d;
        lr_chg      = bit_stb && (lr_s != lr_prev);
        appended    = i2s_mode && (state == ST_SHIFT);
        close_word  = lr_chg && ((state == ST_SHIFT) || (state == ST_FULL));
        closed_left = i2s_mode ? !lr_prev : lr_prev;
        asm_word    = appended ? {sh[W-2:0], data_s} : sh;
        n_close     = cnt + CW'(appended);
        shamt       = CW'(W) - n_close;
        closed      = asm_word << shamt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (bit_stb) nxt = ST_HUNT;
            ST_HUNT:  if (lr_chg) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (lr_chg) nxt = ST_SHIFT;
                else if (bit_stb && (cnt == CW'(W - 1))) nxt = ST_FULL;
            end
            ST_FULL:  if (lr_chg) nxt = ST_SHIFT;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_d     <= 1'b0;
            lr_prev    <= 1'b0;
            sh         <= '0;
            cnt        <= '0;
            left_hold  <= '0;
            have_left  <= 1'b0;
            left_q     <= '0;
            right_q    <= '0;
            pair_valid <= 1'b0;
        end else begin
            bclk_d     <= bclk_s;
            pair_valid <= 1'b0;
            if (bit_stb) lr_prev <= lr_s;

            if (lr_chg && (state != ST_IDLE)) begin
                if (i2s_mode) begin
                    sh  <= '0;
                    cnt <= '0;
                end else begin
                    sh  <= {{(W-1){1'b0}}, data_s};
                    cnt <= CW'(1);
                end
            end else if (bit_stb && (state == ST_SHIFT)) begin
                sh  <= {sh[W-2:0], data_s};
                cnt <= cnt + CW'(1);
            end

            if (close_word) begin
                if (closed_left) begin
                    left_hold <= closed;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_q     <= left_hold;
                    right_q    <= closed;
                    pair_valid <= 1'b1;
                    have_left  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/silence_detect.sv
module silence_detect #(
    parameter int W        = 16,
    parameter int ZERO_RUN = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pair_valid,
    input  logic [W-1:0] left_w,
    input  logic [W-1:0] right_w,
    output logic         silent
);
    localparam int RW = $clog2(ZERO_RUN + 1);

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (pair_valid) begin
            if ((left_w == '0) && (right_w == '0)) begin
                if (run_cnt != RW'(ZERO_RUN)) run_cnt <= run_cnt + RW'(1);
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign silent = (run_cnt == RW'(ZERO_RUN));
endmodule

// File: rtl/pcm_rx_automute.sv
module pcm_rx_automute #(
    parameter int WORD_W      = 16,
    parameter int ZERO_RUN    = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_i2s,
    input  logic              bclk_i,
    input  logic              sdata_i,
    input  logic              lrck_i,
    input  logic              mute_ext_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              pair_valid_o,
    output logic              automute_o,
    output logic              mute_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] synced;

    assign raw_in = {bclk_i, sdata_i, lrck_i};

    bit_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (synced)
    );

    frame_deser #(.W(WORD_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .i2s_mode   (fmt_i2s),
        .bclk_s     (synced[2]),
        .data_s     (synced[1]),
        .lr_s       (synced[0]),
        .left_q     (left_o),
        .right_q    (right_o),
        .pair_valid (pair_valid_o)
    );

    silence_detect #(.W(WORD_W), .ZERO_RUN(ZERO_RUN)) u_silence (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_valid (pair_valid_o),
        .left_w     (left_o),
        .right_w    (right_o),
        .silent     (automute_o)
    );

    assign mute_o = mute_ext_i | automute_o;
endmodule

// File: rtl/pcm_rx_automute_chk.sv
module pcm_rx_automute_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mute_ext_i,
    input logic [WORD_W-1:0] left_o,
    input logic [WORD_W-1:0] right_o,
    input logic              pair_valid_o,
    input logic              automute_o,
    input logic              mute_o
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid_o |=> !pair_valid_o); // R5

    AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_o) |-> pair_valid_o); // R5

    AST_RIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_o) |-> pair_valid_o); // R5

    AST_AUTOMUTE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(automute_o) |-> ($past(pair_valid_o) && ($past(left_o) == '0)
                               && ($past(right_o) == '0))); // R6

    AST_AUTOMUTE_OFF_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(automute_o) |-> ($past(pair_valid_o) && (($past(left_o) != '0)
                               || ($past(right_o) != '0)))); // R8

    AST_EXT_FORCES_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        mute_ext_i |-> mute_o); // R9

    AST_AUTO_FORCES_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        automute_o |-> mute_o); // R9

    AST_NO_SPURIOUS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_ext_i && !automute_o) |-> !mute_o); // R9
endmodule

bind pcm_rx_automute pcm_rx_automute_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mute_ext_i   (mute_ext_i),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o),
    .automute_o   (automute_o),
    .mute_o       (mute_o)
);

// File: tb/sim_pcm_rx_automute.sv
module sim_pcm_rx_automute;
    localparam int RUN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_i2s = 1'b1;
    logic        bclk = 1'b0;
    logic        sdata = 1'b0;
    logic        lrck = 1'b0;
    logic        mute_ext = 1'b0;
    logic [15:0] left_o, right_o;
    logic        pair_valid_o, automute_o, mute_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic last_b = 1'b0;
    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    pcm_rx_automute #(.WORD_W(16), .ZERO_RUN(RUN), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .bclk_i(bclk),
        .sdata_i(sdata), .lrck_i(lrck), .mute_ext_i(mute_ext),
        .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o),
        .automute_o(automute_o), .mute_o(mute_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every delivered pair (R5, R2, R3, R4)
    always @(negedge clk) begin
        if (rst_n && pair_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected pair", {left_o, right_o}, 32'hxxxx_xxxx);
            end else begin
                check("R2/R3/R4/R5 pair data", {left_o, right_o}, exp_q.pop_front());
            end
        end
    end

    function automatic logic pick(input logic [15:0] w, input int j);
        return (j < 16) ? w[15-j] : 1'b1; // bits past the 16th are junk ones
    endfunction

    task automatic slot(input logic lr, input logic d);
        bclk = 1'b0; lrck = lr; sdata = d;
        #20;
        bclk = 1'b1;
        #20;
    endtask

    task automatic send_word(input logic [15:0] w, input logic lr, input int len);
        for (int j = 0; j < len; j++) begin
            if (fmt_i2s) slot(lr, (j == 0) ? last_b : pick(w, j - 1));
            else         slot(lr, pick(w, j));
        end
        last_b = pick(w, len - 1);
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int len);
        exp_q.push_back({l, r});
        send_word(l, fmt_i2s ? 1'b0 : 1'b1, len);
        send_word(r, fmt_i2s ? 1'b1 : 1'b0, len);
    endtask

    task automatic start(input logic mode);
        rst_n = 1'b0;
        fmt_i2s = mode;
        exp_q.delete();
        last_b = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {left_o, right_o}, 32'h0);
        check("R1 reset flags", {31'b0, pair_valid_o | automute_o}, 32'h0);
        rst_n = 1'b1;
        // preamble in the right-channel phase: its word must be dropped (R1, R5)
        for (int k = 0; k < 6; k++) slot(mode ? 1'b1 : 1'b0, 1'b1);
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) slot(fmt_i2s ? 1'b0 : 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        check("R5 all pairs delivered", exp_q.size(), 0);
    endtask

    task automatic frames(input int n, input logic [15:0] l, input logic [15:0] r);
        for (int k = 0; k < n; k++) send_frame(l, r, 16);
        @(negedge clk);
    endtask

    initial begin
        // R2: I2S framing, 16-bit and 24-bit slots (R4)
        start(1'b1);
        send_frame(16'hA5A5, 16'h1234, 16);
        send_frame(16'h8001, 16'h7FFE, 16);
        send_frame(16'hFFFF, 16'h0001, 16);
        send_frame(16'hC3E1, 16'h0F0F, 24);
        send_frame(16'h0002, 16'h8000, 24);
        flush();

        // R3: left-justified framing, 16-bit and 24-bit slots (R4)
        start(1'b0);
        send_frame(16'h5A5A, 16'hFEDC, 16);
        send_frame(16'h0001, 16'h8000, 16);
        send_frame(16'h9876, 16'h4321, 24);
        send_frame(16'hFFFE, 16'h7FFF, 24);
        flush();

        // R6..R9: silence detector and mute combination
        start(1'b1);
        frames(RUN, 16'h0, 16'h0);        // RUN-1 zero pairs delivered so far
        check("R6 not before threshold", automute_o, 0);
        check("R9 no mute source", mute_o, 0);
        frames(1, 16'h0, 16'h0);          // RUN zero pairs delivered
        check("R6 asserted at threshold", automute_o, 1);
        check("R9 mute follows automute", mute_o, 1);
        frames(3, 16'h0, 16'h0);
        check("R7 stays asserted", automute_o, 1);
        frames(1, 16'h0, 16'h0001);       // not yet delivered
        check("R7 held until non-zero delivered", automute_o, 1);
        frames(1, 16'h0, 16'h0);          // non-zero pair now delivered
        check("R8 released on non-zero word", automute_o, 0);
        mute_ext = 1'b1;
        @(negedge clk);
        check("R9 external mute forces", mute_o, 1);
        frames(7, 16'h0, 16'h0);          // RUN-1 zero pairs since release
        check("R8 run count restarted", automute_o, 0);
        check("R9 external mute while short run", mute_o, 1);
        frames(1, 16'h0, 16'h0);
        check("R6 threshold with external mute", automute_o, 1);
        mute_ext = 1'b0;
        @(negedge clk);
        check("R9 automute keeps mute", mute_o, 1);
        frames(1, 16'h8000, 16'h0);
        frames(1, 16'h0, 16'h0);
        check("R8 left non-zero releases", automute_o, 0);
        check("R9 mute cleared", mute_o, 0);
        flush();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule